// File: doc/BRIEF.md
# Keyed Restart Watchdog Timer

A down-counting watchdog with a small word-addressed register port. Software loads a reload value, sets the run bit in the control register, and must then write a fixed 16-bit restart key to the restart register often enough to keep the counter from running out. Each tick from the selected tick source takes one off the counter. A tick that arrives while the counter holds zero is an expiry. The counter is refilled from the reload value at once and keeps counting. The expiry is also reported for one cycle on an interrupt output, a system reset request output and a timeout strobe. Each of these three outputs has its own control bit.

The timeout strobe goes to an external pulse generator, which is not part of this block. The block holds that generator's settings in a pulse configuration register: a width field, an output polarity and a drive type. The polarity and the drive type can each be changed only by writing a key byte into the top byte of that register. The tick source is either a reference tick or a 1 MHz tick enable, both supplied from outside.

Top module: `wdog_top`

## Requirements
- R1: After reset the count reads 0, the reload value reads 0x03EF1480, control and restart read 0, the pulse configuration reads 0x000000FF, and irq_o, sys_rst_req_o and timeout_pulse_o are low.
- R2: A control write (offset 0x0C) that sets bit 0 while bit 0 is clear loads the counter from the reload value. A control write with bit 0 set while bit 0 is already set leaves the count unchanged.
- R3: While running, the count drops by one on each tick of the selected source. Control bit 4 = 1 selects tick_1m_i and bit 4 = 0 selects tick_ref_i. Ticks on the source that is not selected are ignored.
- R4: A selected tick while the count is 0 reloads the counter on that same edge, and counting goes on from there. During the following cycle only, irq_o is high if control bit 2 is set, sys_rst_req_o is high if bit 1 is set, and timeout_pulse_o is high if bit 3 is set.
- R5: Writing exactly the word 0x00004755 to the restart register (offset 0x08) reloads the counter. Any other word leaves the count unchanged. A restart beats a selected tick in the same cycle.
- R6: A control write that clears bit 0 freezes the count, including in the write's own cycle. Ticks have no effect while bit 0 is clear.
- R7: Reads return the count at 0x00, the reload value at 0x04 and the control bits in [5:0] at 0x0C. Offset 0x08 always reads 0.
- R8: At offset 0x18, bits [7:0] are the pulse width and every write to 0x18 updates them. Bit 31 is the polarity: top byte 0xA5 sets it and 0x5A clears it. Bit 30 is the drive type: 0xA8 sets it and 0x8A clears it. Any other top byte leaves both bits as they were. The three fields drive pulse_width_o, pulse_high_o and pulse_push_pull_o.
- R9: full_chip_o follows control bit 5.
- R10: Writing the reload value does not change the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Register access in this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (same cycle, zero when not reading) |
| tick_ref_i | input | 1 | Reference tick enable |
| tick_1m_i | input | 1 | 1 MHz tick enable |
| irq_o | output | 1 | One-cycle expiry interrupt |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| full_chip_o | output | 1 | Reset scope: 1 = full chip, 0 = SoC only |
| timeout_pulse_o | output | 1 | One-cycle strobe to the pulse generator |
| pulse_width_o | output | 8 | Pulse width setting |
| pulse_high_o | output | 1 | Pulse polarity (1 = active high) |
| pulse_push_pull_o | output | 1 | Pulse drive (1 = push-pull, 0 = open drain) |

## Verification
The hardest cases to reach from the ports are the ones where two events land in the same cycle: a tick together with a restart, or a tick together with a control write that clears the run bit. Back-to-back expiries with a reload value of zero are hard to reach as well. The bench drives the tick inputs and the register write on the same clock edge to hit the coincident cases. It sweeps reload values from 0 to 4 against every combination of the three expiry enables, and predicts each count and each output strobe tick by tick with an arithmetic model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned CTRL_W = 6;

    // byte offsets of the registers
    localparam int unsigned OFS_COUNT  = 'h00;
    localparam int unsigned OFS_RELOAD = 'h04;
    localparam int unsigned OFS_KICK   = 'h08;
    localparam int unsigned OFS_CTRL   = 'h0C;
    localparam int unsigned OFS_PULSE  = 'h18;

    // control bit positions
    localparam int unsigned CB_RUN   = 0;
    localparam int unsigned CB_RST   = 1;
    localparam int unsigned CB_IRQ   = 2;
    localparam int unsigned CB_PULSE = 3;
    localparam int unsigned CB_FAST  = 4;
    localparam int unsigned CB_FULL  = 5;

    // key bytes in the top byte of the pulse configuration write
    localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
    localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
    localparam logic [7:0] KEY_DRV_PP   = 8'hA8;
    localparam logic [7:0] KEY_DRV_OD   = 8'h8A;

    typedef struct packed {
        logic irq;
        logic rst;
        logic tmo;
    } wdog_evt_t;
endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
    parameter bit REG_TICK = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fast_sel_i,
    input  logic ref_i,
    input  logic fast_i,
    output logic tick_o
);
    logic sel_tick;

    always_comb begin
        sel_tick = fast_sel_i ? fast_i : ref_i;
    end

    generate
        if (REG_TICK) begin : g_reg
            logic tick_d, tick_q;
            always_comb tick_d = sel_tick;
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) tick_q <= 1'b0;
                else         tick_q <= tick_d;
            end
            assign tick_o = tick_q;
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk_i ^ rst_ni;
            assign tick_o = sel_tick;
        end
    endgenerate
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg import wdog_pkg::*; #(
    parameter int unsigned      ADDR_W     = 5,
    parameter int unsigned      CNT_W      = 32,
    parameter int unsigned      WIDTH_W    = 8,
    parameter logic [CNT_W-1:0] RELOAD_RST = 32'h03EF1480,
    parameter logic [WIDTH_W-1:0] WIDTH_RST = 8'hFF,
    parameter logic [15:0]      KICK_KEY   = 16'h4755
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [BUS_W-1:0]   wdata_i,
    output logic [CNT_W-1:0]   reload_o,
    output logic [CTRL_W-1:0]  ctrl_o,
    output logic [WIDTH_W-1:0] width_o,
    output logic               pol_high_o,
    output logic               push_pull_o,
    output logic               kick_o,
    output logic               en_load_o,
    output logic               run_o
);
    localparam logic [BUS_W-1:0] KICK_WORD = {{(BUS_W-16){1'b0}}, KICK_KEY};

    typedef struct packed {
        logic [CNT_W-1:0]   reload;
        logic [CTRL_W-1:0]  ctrl;
        logic [WIDTH_W-1:0] width;
        logic               hi;
        logic               pp;
    } cfg_t;

    localparam cfg_t CFG_RST = '{reload: RELOAD_RST, ctrl: '0, width: WIDTH_RST,
                                 hi: 1'b0, pp: 1'b0};

    cfg_t cfg_d, cfg_q;
    logic wr_reload, wr_ctrl, wr_kick, wr_pulse;
    logic [7:0] key_byte;

    always_comb begin
        wr_reload = wr_i && (addr_i == ADDR_W'(OFS_RELOAD));
        wr_ctrl   = wr_i && (addr_i == ADDR_W'(OFS_CTRL));
        wr_kick   = wr_i && (addr_i == ADDR_W'(OFS_KICK));
        wr_pulse  = wr_i && (addr_i == ADDR_W'(OFS_PULSE));
        key_byte  = wdata_i[BUS_W-1 -: 8];

        cfg_d = cfg_q;
        if (wr_reload) cfg_d.reload = wdata_i[CNT_W-1:0];
        if (wr_ctrl)   cfg_d.ctrl   = wdata_i[CTRL_W-1:0];
        if (wr_pulse) begin
            cfg_d.width = wdata_i[WIDTH_W-1:0];
            case (key_byte)
                KEY_POL_HIGH: cfg_d.hi = 1'b1;
                KEY_POL_LOW:  cfg_d.hi = 1'b0;
                KEY_DRV_PP:   cfg_d.pp = 1'b1;
                KEY_DRV_OD:   cfg_d.pp = 1'b0;
                default:      ;
            endcase
        end

        kick_o    = wr_kick && (wdata_i == KICK_WORD);
        en_load_o = wr_ctrl && wdata_i[CB_RUN] && !cfg_q.ctrl[CB_RUN];
        run_o     = wr_ctrl ? wdata_i[CB_RUN] : cfg_q.ctrl[CB_RUN];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= CFG_RST;
        else         cfg_q <= cfg_d;
    end

    assign reload_o    = cfg_q.reload;
    assign ctrl_o      = cfg_q.ctrl;
    assign width_o     = cfg_q.width;
    assign pol_high_o  = cfg_q.hi;
    assign push_pull_o = cfg_q.pp;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (load_i) begin
            st_d.cnt = reload_i;
        end else if (run_i && tick_i) begin
            if (st_q.cnt == '0) begin
                expire_o = 1'b1;
                st_d.cnt = reload_i;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign count_o = st_q.cnt;
endmodule

// File: rtl/wdog_top.sv
module wdog_top import wdog_pkg::*; #(
    parameter int unsigned        ADDR_W     = 5,
    parameter int unsigned        CNT_W      = 32,
    parameter int unsigned        WIDTH_W    = 8,
    parameter logic [CNT_W-1:0]   RELOAD_RST = 32'h03EF1480,
    parameter logic [WIDTH_W-1:0] WIDTH_RST  = 8'hFF,
    parameter logic [15:0]        KICK_KEY   = 16'h4755,
    parameter bit                 REG_TICK   = 1'b0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               bus_valid_i,
    input  logic               bus_write_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [BUS_W-1:0]   bus_wdata_i,
    output logic [BUS_W-1:0]   bus_rdata_o,
    input  logic               tick_ref_i,
    input  logic               tick_1m_i,
    output logic               irq_o,
    output logic               sys_rst_req_o,
    output logic               full_chip_o,
    output logic               timeout_pulse_o,
    output logic [WIDTH_W-1:0] pulse_width_o,
    output logic               pulse_high_o,
    output logic               pulse_push_pull_o
);
    // width field must stay clear of the two flag bits and the key byte
    localparam int unsigned PAD_W = BUS_W - 2 - WIDTH_W;

    logic [CNT_W-1:0]  reload_w, cnt_w;
    logic [CTRL_W-1:0] ctrl_w;
    logic              kick_w, en_load_w, run_w, load_w, tick_w, expire_w;
    wdog_evt_t         evt_d, evt_q;

    wdog_cfg #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WIDTH_W(WIDTH_W),
        .RELOAD_RST(RELOAD_RST), .WIDTH_RST(WIDTH_RST), .KICK_KEY(KICK_KEY)
    ) i_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (bus_valid_i && bus_write_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .reload_o   (reload_w),
        .ctrl_o     (ctrl_w),
        .width_o    (pulse_width_o),
        .pol_high_o (pulse_high_o),
        .push_pull_o(pulse_push_pull_o),
        .kick_o     (kick_w),
        .en_load_o  (en_load_w),
        .run_o      (run_w)
    );

    wdog_tick #(.REG_TICK(REG_TICK)) i_tick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fast_sel_i(ctrl_w[CB_FAST]),
        .ref_i     (tick_ref_i),
        .fast_i    (tick_1m_i),
        .tick_o    (tick_w)
    );

    assign load_w = kick_w || en_load_w;

    wdog_counter #(.CNT_W(CNT_W)) i_counter (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load_w),
        .run_i   (run_w),
        .tick_i  (tick_w),
        .reload_i(reload_w),
        .count_o (cnt_w),
        .expire_o(expire_w)
    );

    always_comb begin
        evt_d.irq = expire_w && ctrl_w[CB_IRQ];
        evt_d.rst = expire_w && ctrl_w[CB_RST];
        evt_d.tmo = expire_w && ctrl_w[CB_PULSE];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) evt_q <= '0;
        else         evt_q <= evt_d;
    end

    assign irq_o           = evt_q.irq;
    assign sys_rst_req_o   = evt_q.rst;
    assign timeout_pulse_o = evt_q.tmo;
    assign full_chip_o     = ctrl_w[CB_FULL];

    always_comb begin
        bus_rdata_o = '0;
        if (bus_valid_i && !bus_write_i) begin
            case (bus_addr_i)
                ADDR_W'(OFS_COUNT):  bus_rdata_o = BUS_W'(cnt_w);
                ADDR_W'(OFS_RELOAD): bus_rdata_o = BUS_W'(reload_w);
                ADDR_W'(OFS_CTRL):   bus_rdata_o = BUS_W'(ctrl_w);
                ADDR_W'(OFS_PULSE):  bus_rdata_o = {pulse_high_o, pulse_push_pull_o,
                                                    {PAD_W{1'b0}}, pulse_width_o};
                default:             bus_rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk import wdog_pkg::*; #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned CNT_W  = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_valid_i,
    input logic              bus_write_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [BUS_W-1:0]  bus_rdata_i,
    input logic [CNT_W-1:0]  cnt_i,
    input logic [CNT_W-1:0]  reload_i,
    input logic [CTRL_W-1:0] ctrl_i,
    input logic              run_i,
    input logic              load_i,
    input logic              irq_i,
    input logic              tmo_i,
    input logic              pol_i
);
    // R3
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (cnt_i == $past(cnt_i)) || (cnt_i == $past(cnt_i) - CNT_W'(1))
                 || (cnt_i == $past(reload_i)));

    // R6
    halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !load_i) |=> $stable(cnt_i));

    // R4
    irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |-> ($past(cnt_i) == '0) && $past(ctrl_i[CB_IRQ]));

    // R4
    tmo_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmo_i |-> $past(ctrl_i[CB_PULSE]));

    // R7
    kick_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_valid_i && !bus_write_i && bus_addr_i == ADDR_W'(OFS_KICK))
            |-> bus_rdata_i == '0);

    // R8
    pol_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pol_i != $past(pol_i)) |->
            $past(bus_valid_i && bus_write_i && bus_addr_i == ADDR_W'(OFS_PULSE)));
endmodule

bind wdog_top wdog_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_wdog_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_valid_i(bus_valid_i),
    .bus_write_i(bus_write_i),
    .bus_addr_i (bus_addr_i),
    .bus_rdata_i(bus_rdata_o),
    .cnt_i      (cnt_w),
    .reload_i   (reload_w),
    .ctrl_i     (ctrl_w),
    .run_i      (run_w),
    .load_i     (load_w),
    .irq_i      (irq_o),
    .tmo_i      (timeout_pulse_o),
    .pol_i      (pulse_high_o)
);

// File: tb/test_wdog_top.sv
`timescale 1ns/100ps
module test_wdog_top;
    localparam logic [4:0] A_CNT = 5'h00, A_REL = 5'h04, A_KICK = 5'h08,
                           A_CTRL = 5'h0C, A_PW = 5'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_ref = 1'b0, tick_1m = 1'b0;
    logic        irq, srst, full_chip, tmo, p_high, p_pp;
    logic [7:0]  p_width;

    int n_chk = 0;
    int n_bad = 0;
    logic irq_s, rst_s, tmo_s;
    logic [31:0] v;

    always #2.5 clk = ~clk;

    wdog_top i_wdog_top (
        .clk_i(clk), .rst_ni(rst_n),
        .bus_valid_i(bus_valid), .bus_write_i(bus_write),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .tick_ref_i(tick_ref), .tick_1m_i(tick_1m),
        .irq_o(irq), .sys_rst_req_o(srst), .full_chip_o(full_chip),
        .timeout_pulse_o(tmo), .pulse_width_o(p_width),
        .pulse_high_o(p_high), .pulse_push_pull_o(p_pp)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    // write and a reference tick on the same edge
    task automatic bus_wr_tick(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        tick_ref = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; tick_ref = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        #1 bus_valid = 1'b0;
    endtask

    task automatic do_tick(input logic r, input logic f);
        @(negedge clk);
        tick_ref = r; tick_1m = f;
        @(negedge clk);
        tick_ref = 1'b0; tick_1m = 1'b0;
        irq_s = irq; rst_s = srst; tmo_s = tmo;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements) act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(A_CNT, v);  chk("R1 count", v, 32'h0);
        bus_rd(A_REL, v);  chk("R1 reload", v, 32'h03EF1480);
        bus_rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
        bus_rd(A_KICK, v); chk("R1 restart", v, 32'h0);
        bus_rd(A_PW, v);   chk("R1 pulse cfg", v, 32'h000000FF);
        chk("R1 outputs", {29'b0, irq, srst, tmo}, 32'h0);

        // R2 R3 R4 sweep: reload 0..4, every combination of expiry enables
        for (int r = 0; r < 5; r++) begin
            for (int m = 0; m < 8; m++) begin
                int exp_c;
                logic [31:0] cw;
                cw = 32'h1 | (m[1] ? 32'h2 : 32'h0) | (m[0] ? 32'h4 : 32'h0)
                           | (m[2] ? 32'h8 : 32'h0);
                bus_wr(A_CTRL, 32'h0);
                bus_wr(A_REL, r);
                bus_wr(A_CTRL, cw);
                bus_rd(A_CNT, v); chk("R2 load on enable", v, r);
                exp_c = r;
                for (int k = 0; k < 2 * r + 3; k++) begin
                    logic fire;
                    do_tick(1'b1, 1'b0);
                    fire = (exp_c == 0);
                    exp_c = fire ? r : exp_c - 1;
                    chk("R4 irq", {31'b0, irq_s}, {31'b0, fire & m[0]});
                    chk("R4 reset req", {31'b0, rst_s}, {31'b0, fire & m[1]});
                    chk("R4 timeout strobe", {31'b0, tmo_s}, {31'b0, fire & m[2]});
                    bus_rd(A_CNT, v); chk("R3 count step", v, exp_c);
                    chk("R4 one cycle", {29'b0, irq, srst, tmo}, 32'h0);
                end
            end
        end

        // R2 re-enable while running does not reload
        bus_wr(A_CTRL, 32'h0);
        bus_wr(A_REL, 32'd10);
        bus_wr(A_CTRL, 32'h1);
        do_tick(1'b1, 1'b0); do_tick(1'b1, 1'b0); do_tick(1'b1, 1'b0);
        bus_rd(A_CNT, v); chk("R3 three ticks", v, 32'd7);
        bus_wr(A_CTRL, 32'h1);
        bus_rd(A_CNT, v); chk("R2 no reload when already on", v, 32'd7);

        // R3 tick source selection
        do_tick(1'b0, 1'b1);
        bus_rd(A_CNT, v); chk("R3 1MHz ignored", v, 32'd7);
        bus_wr(A_CTRL, 32'h11);
        bus_rd(A_CNT, v); chk("R3 stays on select", v, 32'd7);
        do_tick(1'b1, 1'b0);
        bus_rd(A_CNT, v); chk("R3 ref ignored", v, 32'd7);
        do_tick(1'b0, 1'b1);
        bus_rd(A_CNT, v); chk("R3 1MHz counts", v, 32'd6);
        bus_rd(A_CTRL, v); chk("R7 ctrl readback", v, 32'h11);
        bus_wr(A_CTRL, 32'h1);

        // R5 restart key
        bus_wr(A_KICK, 32'h00004754);
        bus_rd(A_CNT, v); chk("R5 wrong key", v, 32'd6);
        bus_wr(A_KICK, 32'h00014755);
        bus_rd(A_CNT, v); chk("R5 upper bits set", v, 32'd6);
        bus_wr(A_KICK, 32'h00004755);
        bus_rd(A_CNT, v); chk("R5 key reloads", v, 32'd10);
        do_tick(1'b1, 1'b0);
        bus_wr_tick(A_KICK, 32'h00004755);
        bus_rd(A_CNT, v); chk("R5 restart beats tick", v, 32'd10);
        bus_rd(A_KICK, v); chk("R7 restart reads zero", v, 32'h0);

        // R10 reload write while running
        bus_wr(A_REL, 32'd20);
        bus_rd(A_CNT, v); chk("R10 count kept", v, 32'd10);
        bus_rd(A_REL, v); chk("R7 reload readback", v, 32'd20);
        bus_wr(A_KICK, 32'h00004755);
        bus_rd(A_CNT, v); chk("R10 new reload used", v, 32'd20);

        // R6 disable with coincident tick, then ticks while off
        bus_wr_tick(A_CTRL, 32'h0);
        bus_rd(A_CNT, v); chk("R6 frozen in write cycle", v, 32'd20);
        do_tick(1'b1, 1'b0); do_tick(1'b1, 1'b1);
        bus_rd(A_CNT, v); chk("R6 ticks ignored while off", v, 32'd20);

        // R9 reset scope
        chk("R9 soc only", {31'b0, full_chip}, 32'h0);
        bus_wr(A_CTRL, 32'h20);
        chk("R9 full chip", {31'b0, full_chip}, 32'h1);
        bus_wr(A_CTRL, 32'h0);
        chk("R9 back to soc", {31'b0, full_chip}, 32'h0);

        // R8 pulse configuration keys
        bus_wr(A_PW, 32'hA80000FF);
        bus_rd(A_PW, v); chk("R8 push-pull key", v, 32'h400000FF);
        bus_wr(A_PW, 32'hA50000FF);
        bus_rd(A_PW, v); chk("R8 high key", v, 32'hC00000FF);
        bus_wr(A_PW, 32'h5A000012);
        bus_rd(A_PW, v); chk("R8 low key and width", v, 32'h40000012);
        chk("R8 width port", {24'b0, p_width}, 32'h12);
        chk("R8 flag ports", {30'b0, p_high, p_pp}, 32'h1);
        bus_wr(A_PW, 32'h000A5A5A);
        bus_rd(A_PW, v); chk("R8 no key keeps flags", v, 32'h4000005A);
        bus_wr(A_PW, 32'h8A0000FF);
        bus_rd(A_PW, v); chk("R8 open-drain key", v, 32'h000000FF);
        chk("R8 flag ports cleared", {30'b0, p_high, p_pp}, 32'h0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule